// File: doc/BRIEF.md
# Tag Write Command Sequence Parser

This block sits behind the gap decoder of a contactless tag front end. The decoder marks the start of a command with `frame_start` and its end with `frame_end`. Between the two it delivers one data bit per `bit_valid` strobe. The parser collects these bits into a command frame and checks the opcode, the frame length and, where needed, a 32-bit password. When the frame is complete it issues exactly one verdict: a block write, a test-mode write, a reset request, a wake-up, or a fall-back to read mode.

The layout of a frame depends on its opcode and on the protection-enable input. Page-select opcodes (`10`, `11`) carry a lock bit, 32 data bits and a 3-bit block address. When protection is on, a password comes before that payload. A password-only frame with opcode `10` wakes the tag. Opcode `00` asks the system for a power-on-reset cycle. Opcode `01` carries a test-mode write, and that write is refused once the master-key field equals 6. Any malformed frame leaves the selected read page as it was and raises the fall-back strobe.

The sequencer has these states:
- `ST_IDLE` waits for a frame start.
- `ST_OPCODE` takes the two opcode bits.
- `ST_PASSWORD` takes 32 password bits.
- `ST_PAYLOAD` takes lock, data and address.
- `ST_OVERRUN` absorbs excess bits.
- `ST_COMMIT` issues the verdict for one cycle.

The transitions are:
- A frame start enters `ST_OPCODE` from any state.
- `ST_OPCODE` goes to `ST_PASSWORD` after the second bit when that bit pair is `1x` and protection is on. Otherwise it goes to `ST_PAYLOAD`.
- `ST_PASSWORD` goes to `ST_PAYLOAD` after the 32nd bit.
- `ST_PAYLOAD` goes to `ST_OVERRUN` on a 37th payload bit.
- Every active state goes to `ST_COMMIT` on a frame end.
- `ST_COMMIT` returns to `ST_IDLE`.

Top module: `cmd_seq_parser`

## Requirements
- R1: The first two bits after `frame_start` form the opcode, first bit in the MSB. Bits and frame ends seen while no frame is open have no effect, and a bit in the same cycle as `frame_start` is discarded.
- R2: With `prot_en`=0, a frame of opcode `1x`, lock, 32 data bits (MSB first) and a 3-bit address (MSB first) is a standard write of exactly 38 bits. It yields `wr_req` with `wr_test`=0, `wr_page` equal to the opcode LSB, and the captured lock, data and address.
- R3: With `prot_en`=1, a write with opcode `1x` carries a 32-bit password (MSB first) between the opcode and the lock bit, for 70 bits in total. The write is issued only if the password equals `stored_pwd`.
- R4: A frame of opcode `10` followed by a 32-bit password (34 bits total) that matches `stored_pwd` pulses `wake` and selects page 0. A 34-bit frame with opcode `11` is invalid.
- R5: A frame consisting only of opcode `00` (exactly 2 bits) pulses `rst_req`.
- R6: Opcode `01` followed by lock, data and address (38 bits, never with a password) yields `wr_req` with `wr_test`=1 and `wr_page`=0. When `master_key` equals 6, the frame is ignored: no strobe of any kind and no page change.
- R7: A wrong length, an excess bit, a password mismatch, or a zero-bit frame pulses `fallback` alone, with no other strobe, and `rd_page` keeps its value.
- R8: `rd_page` resets to 0 and changes only on an accepted page-select write (to the opcode LSB) or an accepted wake-up (to 0).
- R9: A bit that arrives together with `frame_end` is the last bit of the frame. Every verdict strobe is one cycle wide and appears two clock edges after the edge that sampled `frame_end`.
- R10: A page-0 write to block 0 is refused with `fallback` while `blk0_lock` is 1. Block 0 on page 1 is still writable.
- R11: A `frame_start` inside an open frame abandons that frame and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Start gap detected, opens a frame |
| frame_end | input | 1 | Frame finished, triggers evaluation |
| bit_valid | input | 1 | One decoded bit present |
| bit_val | input | 1 | Value of the decoded bit |
| prot_en | input | 1 | Password protection enabled |
| stored_pwd | input | 32 | Reference password |
| master_key | input | 4 | Master-key field of block 0 |
| blk0_lock | input | 1 | Lock bit of block 0 |
| wr_req | output | 1 | One-cycle write request |
| wr_test | output | 1 | Write request is a test-mode write |
| wr_page | output | 1 | Page of the write |
| wr_blk | output | 3 | Block address of the write |
| wr_lock | output | 1 | Lock bit of the write |
| wr_data | output | 32 | Data word of the write |
| rst_req | output | 1 | One-cycle power-on-reset request |
| wake | output | 1 | One-cycle wake-up strobe |
| fallback | output | 1 | One-cycle invalid-frame strobe |
| rd_page | output | 1 | Currently selected read page |

## Verification
Two events can fall in the same cycle: a frame's last data bit and the end-of-frame mark. The parser must count that bit before it judges the length. The vector table alternates between ending each frame with the last bit and ending it one gap later. In both cases the bench expects the same verdict, timed two edges after the end mark. A frame start that lands inside an open frame is a second collision. It is provoked mid-frame, and the bench requires only the new frame's verdict.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_PASSWORD,
        ST_PAYLOAD,
        ST_OVERRUN,
        ST_COMMIT
    } seq_state_t;

    typedef enum logic [2:0] {
        V_IGNORE,
        V_WRITE,
        V_TEST,
        V_RESET,
        V_WAKE,
        V_FALLBACK
    } verdict_t;

    localparam int OP_W = 2;

endpackage

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import cmd_seq_pkg::*;
#(
    parameter int PWD_W = 32,
    parameter int PAY_W = 36,
    parameter int PC_W  = $clog2(PWD_W + 1),
    parameter int YC_W  = $clog2(PAY_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic                 bit_valid,
    input  logic                 bit_val,
    input  logic                 prot_en,
    output seq_state_t           state,
    output logic [OP_W-1:0]      opcode,
    output logic [1:0]           op_cnt,
    output logic [PC_W-1:0]      pwd_cnt,
    output logic [YC_W-1:0]      pay_cnt,
    output logic                 ovf,
    output logic                 prot_lat,
    output logic                 shift_en,
    output logic                 pwd_last
);

    localparam logic [PC_W-1:0] PWD_LAST_IDX = PC_W'(PWD_W - 1);
    localparam logic [YC_W-1:0] PAY_FULL     = YC_W'(PAY_W);

    seq_state_t state_nxt;
    logic       bit_take;

    assign bit_take = bit_valid && !frame_start;

    // next-state decision
    always_comb begin
        state_nxt = state;
        if (frame_start) begin
            state_nxt = ST_OPCODE;
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_OPCODE: begin
                    if (frame_end)
                        state_nxt = ST_COMMIT;
                    else if (bit_valid && op_cnt == 2'd1)
                        state_nxt = (opcode[0] && prot_en) ? ST_PASSWORD : ST_PAYLOAD;
                end
                ST_PASSWORD: begin
                    if (frame_end)
                        state_nxt = ST_COMMIT;
                    else if (bit_valid && pwd_cnt == PWD_LAST_IDX)
                        state_nxt = ST_PAYLOAD;
                end
                ST_PAYLOAD: begin
                    if (frame_end)
                        state_nxt = ST_COMMIT;
                    else if (bit_valid && pay_cnt == PAY_FULL)
                        state_nxt = ST_OVERRUN;
                end
                ST_OVERRUN: begin
                    if (frame_end)
                        state_nxt = ST_COMMIT;
                end
                ST_COMMIT: state_nxt = ST_IDLE;
                default:   state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // field counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode   <= '0;
            op_cnt   <= '0;
            pwd_cnt  <= '0;
            pay_cnt  <= '0;
            ovf      <= 1'b0;
            prot_lat <= 1'b0;
        end else if (frame_start) begin
            opcode   <= '0;
            op_cnt   <= '0;
            pwd_cnt  <= '0;
            pay_cnt  <= '0;
            ovf      <= 1'b0;
            prot_lat <= 1'b0;
        end else if (bit_valid) begin
            unique case (state)
                ST_OPCODE: begin
                    opcode <= {opcode[0], bit_val};
                    op_cnt <= op_cnt + 2'd1;
                    if (op_cnt == 2'd1)
                        prot_lat <= prot_en;
                end
                ST_PASSWORD: pwd_cnt <= pwd_cnt + PC_W'(1);
                ST_PAYLOAD: begin
                    if (pay_cnt == PAY_FULL)
                        ovf <= 1'b1;
                    else
                        pay_cnt <= pay_cnt + YC_W'(1);
                end
                ST_OVERRUN: ovf <= 1'b1;
                default: ;
            endcase
        end
    end

    assign shift_en = bit_take &&
                      ((state == ST_PASSWORD) ||
                       (state == ST_PAYLOAD && pay_cnt != PAY_FULL));
    assign pwd_last = bit_take && (state == ST_PASSWORD) && (pwd_cnt == PWD_LAST_IDX);

endmodule

// File: rtl/cmd_seq_shift.sv
module cmd_seq_shift #(
    parameter int PWD_W = 32,
    parameter int PAY_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             shift_en,
    input  logic             pwd_last,
    input  logic             bit_val,
    input  logic [PWD_W-1:0] stored_pwd,
    output logic [PAY_W-1:0] sreg,
    output logic             pwd_ok
);

    logic [PWD_W-1:0] pwd_view;

    // password as it stands once the incoming bit is appended
    assign pwd_view = {sreg[PWD_W-2:0], bit_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg   <= '0;
            pwd_ok <= 1'b0;
        end else if (frame_start) begin
            sreg   <= '0;
            pwd_ok <= 1'b0;
        end else if (shift_en) begin
            sreg <= {sreg[PAY_W-2:0], bit_val};
            if (pwd_last)
                pwd_ok <= (pwd_view == stored_pwd);
        end
    end

endmodule

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
    import cmd_seq_pkg::*;
#(
    parameter int PWD_W      = 32,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int KEY_W      = 4,
    parameter int KEY_LOCKED = 6,
    parameter int PAY_W      = 1 + DATA_W + ADDR_W,
    parameter int PC_W       = $clog2(PWD_W + 1),
    parameter int YC_W       = $clog2(PAY_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [OP_W-1:0]   opcode,
    input  logic [1:0]        op_cnt,
    input  logic [PC_W-1:0]   pwd_cnt,
    input  logic [YC_W-1:0]   pay_cnt,
    input  logic              ovf,
    input  logic              prot_lat,
    input  logic              pwd_ok,
    input  logic [PAY_W-1:0]  sreg,
    input  logic [PWD_W-1:0]  stored_pwd,
    input  logic [KEY_W-1:0]  master_key,
    input  logic              blk0_lock,
    output logic              wr_req,
    output logic              wr_test,
    output logic              wr_page,
    output logic [ADDR_W-1:0] wr_blk,
    output logic              wr_lock,
    output logic [DATA_W-1:0] wr_data,
    output logic              rst_req,
    output logic              wake,
    output logic              fallback,
    output logic              rd_page
);

    localparam logic [PC_W-1:0] PWD_FULL    = PC_W'(PWD_W);
    localparam logic [YC_W-1:0] PAY_FULL    = YC_W'(PAY_W);
    localparam logic [YC_W-1:0] PWD_AS_PAY  = YC_W'(PWD_W);
    localparam logic [KEY_W-1:0] KEY_VAL    = KEY_W'(KEY_LOCKED);

    verdict_t          verdict;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              f_lock;
    logic              blocked;
    logic              key_hit;
    logic              raw_pwd_ok;

    assign f_addr     = sreg[ADDR_W-1:0];
    assign f_data     = sreg[ADDR_W +: DATA_W];
    assign f_lock     = sreg[PAY_W-1];
    assign blocked    = blk0_lock && (f_addr == '0) && !opcode[0];
    assign key_hit    = (master_key == KEY_VAL);
    assign raw_pwd_ok = (sreg[PWD_W-1:0] == stored_pwd);

    // frame judgement
    always_comb begin
        verdict = V_FALLBACK;
        if (op_cnt == 2'd2 && !ovf) begin
            unique case (opcode)
                2'b00: begin
                    if (pwd_cnt == '0 && pay_cnt == '0)
                        verdict = V_RESET;
                end
                2'b01: begin
                    if (pay_cnt == PAY_FULL)
                        verdict = key_hit ? V_IGNORE : V_TEST;
                end
                default: begin
                    if (prot_lat) begin
                        if (pwd_cnt == PWD_FULL) begin
                            if (pay_cnt == '0 && !opcode[0])
                                verdict = pwd_ok ? V_WAKE : V_FALLBACK;
                            else if (pay_cnt == PAY_FULL)
                                verdict = (pwd_ok && !blocked) ? V_WRITE : V_FALLBACK;
                        end
                    end else begin
                        if (pay_cnt == PWD_AS_PAY && !opcode[0])
                            verdict = raw_pwd_ok ? V_WAKE : V_FALLBACK;
                        else if (pay_cnt == PAY_FULL)
                            verdict = blocked ? V_FALLBACK : V_WRITE;
                    end
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_req   <= 1'b0;
            wr_test  <= 1'b0;
            wr_page  <= 1'b0;
            wr_blk   <= '0;
            wr_lock  <= 1'b0;
            wr_data  <= '0;
            rst_req  <= 1'b0;
            wake     <= 1'b0;
            fallback <= 1'b0;
            rd_page  <= 1'b0;
        end else begin
            wr_req   <= 1'b0;
            rst_req  <= 1'b0;
            wake     <= 1'b0;
            fallback <= 1'b0;
            if (commit) begin
                unique case (verdict)
                    V_WRITE: begin
                        wr_req  <= 1'b1;
                        wr_test <= 1'b0;
                        wr_page <= opcode[0];
                        wr_blk  <= f_addr;
                        wr_lock <= f_lock;
                        wr_data <= f_data;
                        rd_page <= opcode[0];
                    end
                    V_TEST: begin
                        wr_req  <= 1'b1;
                        wr_test <= 1'b1;
                        wr_page <= 1'b0;
                        wr_blk  <= f_addr;
                        wr_lock <= f_lock;
                        wr_data <= f_data;
                    end
                    V_RESET:    rst_req  <= 1'b1;
                    V_WAKE: begin
                        wake    <= 1'b1;
                        rd_page <= 1'b0;
                    end
                    V_FALLBACK: fallback <= 1'b1;
                    V_IGNORE:   ;
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmd_seq_parser.sv
module cmd_seq_parser
    import cmd_seq_pkg::*;
#(
    parameter int PWD_W      = 32,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int KEY_W      = 4,
    parameter int KEY_LOCKED = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic              prot_en,
    input  logic [PWD_W-1:0]  stored_pwd,
    input  logic [KEY_W-1:0]  master_key,
    input  logic              blk0_lock,
    output logic              wr_req,
    output logic              wr_test,
    output logic              wr_page,
    output logic [ADDR_W-1:0] wr_blk,
    output logic              wr_lock,
    output logic [DATA_W-1:0] wr_data,
    output logic              rst_req,
    output logic              wake,
    output logic              fallback,
    output logic              rd_page
);

    localparam int PAY_W = 1 + DATA_W + ADDR_W;
    localparam int PC_W  = $clog2(PWD_W + 1);
    localparam int YC_W  = $clog2(PAY_W + 1);

    seq_state_t       state;
    logic [OP_W-1:0]  opcode;
    logic [1:0]       op_cnt;
    logic [PC_W-1:0]  pwd_cnt;
    logic [YC_W-1:0]  pay_cnt;
    logic             ovf;
    logic             prot_lat;
    logic             shift_en;
    logic             pwd_last;
    logic [PAY_W-1:0] sreg;
    logic             pwd_ok;
    logic             commit;

    assign commit = (state == ST_COMMIT);

    cmd_seq_fsm #(
        .PWD_W (PWD_W),
        .PAY_W (PAY_W),
        .PC_W  (PC_W),
        .YC_W  (YC_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .bit_valid   (bit_valid),
        .bit_val     (bit_val),
        .prot_en     (prot_en),
        .state       (state),
        .opcode      (opcode),
        .op_cnt      (op_cnt),
        .pwd_cnt     (pwd_cnt),
        .pay_cnt     (pay_cnt),
        .ovf         (ovf),
        .prot_lat    (prot_lat),
        .shift_en    (shift_en),
        .pwd_last    (pwd_last)
    );

    cmd_seq_shift #(
        .PWD_W (PWD_W),
        .PAY_W (PAY_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .shift_en    (shift_en),
        .pwd_last    (pwd_last),
        .bit_val     (bit_val),
        .stored_pwd  (stored_pwd),
        .sreg        (sreg),
        .pwd_ok      (pwd_ok)
    );

    cmd_seq_decode #(
        .PWD_W      (PWD_W),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .KEY_W      (KEY_W),
        .KEY_LOCKED (KEY_LOCKED),
        .PAY_W      (PAY_W),
        .PC_W       (PC_W),
        .YC_W       (YC_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .opcode     (opcode),
        .op_cnt     (op_cnt),
        .pwd_cnt    (pwd_cnt),
        .pay_cnt    (pay_cnt),
        .ovf        (ovf),
        .prot_lat   (prot_lat),
        .pwd_ok     (pwd_ok),
        .sreg       (sreg),
        .stored_pwd (stored_pwd),
        .master_key (master_key),
        .blk0_lock  (blk0_lock),
        .wr_req     (wr_req),
        .wr_test    (wr_test),
        .wr_page    (wr_page),
        .wr_blk     (wr_blk),
        .wr_lock    (wr_lock),
        .wr_data    (wr_data),
        .rst_req    (rst_req),
        .wake       (wake),
        .fallback   (fallback),
        .rd_page    (rd_page)
    );

endmodule

// File: rtl/cmd_seq_parser_chk.sv
module cmd_seq_parser_chk #(
    parameter int KEY_W      = 4,
    parameter int KEY_LOCKED = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [KEY_W-1:0] master_key,
    input logic             wr_req,
    input logic             wr_test,
    input logic             wr_page,
    input logic             rst_req,
    input logic             wake,
    input logic             fallback,
    input logic             rd_page
);

    // R7: at most one verdict strobe per cycle
    p_single_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_req, rst_req, wake, fallback}));

    // R9: write strobe is one cycle wide
    p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    // R5: reset request is one cycle wide
    p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4: wake-up leaves page 0 selected
    p_wake_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (rd_page == 1'b0));

    // R6: test write targets page 0 and never with the master key at its locking value
    p_test_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_test) |-> (wr_page == 1'b0));

    p_test_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_test) |-> ($past(master_key) != KEY_W'(KEY_LOCKED)));

    // R8: read page moves only with an accepted page write or wake-up
    p_page_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_page) |-> (wake || (wr_req && !wr_test)));

    // R7: fall-back keeps the page
    p_fallback_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fallback |-> $stable(rd_page));

endmodule

bind cmd_seq_parser cmd_seq_parser_chk #(
    .KEY_W      (KEY_W),
    .KEY_LOCKED (KEY_LOCKED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_key (master_key),
    .wr_req     (wr_req),
    .wr_test    (wr_test),
    .wr_page    (wr_page),
    .rst_req    (rst_req),
    .wake       (wake),
    .fallback   (fallback),
    .rd_page    (rd_page)
);

// File: tb/tb_cmd_seq_parser.sv
module tb_cmd_seq_parser;

    localparam logic [2:0] E_NONE = 3'd0;
    localparam logic [2:0] E_WR   = 3'd1;
    localparam logic [2:0] E_TEST = 3'd2;
    localparam logic [2:0] E_RST  = 3'd3;
    localparam logic [2:0] E_WAKE = 3'd4;
    localparam logic [2:0] E_FB   = 3'd5;

    localparam logic [31:0] PWD = 32'hC0DE1234;

    typedef struct packed {
        logic       prot;
        logic       key6;
        logic       lk0;
        logic [1:0] op;
        logic [1:0] shape;   // 0 opcode only, 1 password only, 2 write body
        logic       pgood;
        logic [1:0] trim;    // 0 exact, 1 drop last bit, 2 one extra bit
        logic [2:0] addr;
        logic [2:0] exp;
        logic       exp_page;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,2'b10,2'd2,1'b1,2'd0,3'd5,E_WR,  1'b0},
        '{1'b0,1'b0,1'b0,2'b11,2'd2,1'b1,2'd0,3'd3,E_WR,  1'b1},
        '{1'b0,1'b0,1'b0,2'b11,2'd2,1'b1,2'd1,3'd3,E_FB,  1'b1},
        '{1'b1,1'b0,1'b0,2'b10,2'd2,1'b1,2'd0,3'd6,E_WR,  1'b0},
        '{1'b1,1'b0,1'b0,2'b11,2'd2,1'b0,2'd0,3'd6,E_FB,  1'b0},
        '{1'b0,1'b0,1'b0,2'b11,2'd2,1'b1,2'd0,3'd7,E_WR,  1'b1},
        '{1'b0,1'b0,1'b0,2'b10,2'd1,1'b1,2'd0,3'd0,E_WAKE,1'b0},
        '{1'b1,1'b0,1'b0,2'b10,2'd1,1'b0,2'd0,3'd0,E_FB,  1'b0},
        '{1'b0,1'b0,1'b0,2'b11,2'd1,1'b1,2'd0,3'd0,E_FB,  1'b0},
        '{1'b0,1'b0,1'b0,2'b00,2'd0,1'b1,2'd0,3'd0,E_RST, 1'b0},
        '{1'b0,1'b0,1'b0,2'b00,2'd0,1'b1,2'd2,3'd0,E_FB,  1'b0},
        '{1'b0,1'b0,1'b0,2'b01,2'd2,1'b1,2'd0,3'd2,E_TEST,1'b0},
        '{1'b0,1'b1,1'b0,2'b01,2'd2,1'b1,2'd0,3'd2,E_NONE,1'b0},
        '{1'b1,1'b1,1'b0,2'b01,2'd2,1'b1,2'd0,3'd4,E_NONE,1'b0},
        '{1'b0,1'b0,1'b0,2'b10,2'd2,1'b1,2'd2,3'd1,E_FB,  1'b0},
        '{1'b0,1'b0,1'b0,2'b01,2'd2,1'b1,2'd1,3'd1,E_FB,  1'b0},
        '{1'b0,1'b0,1'b1,2'b10,2'd2,1'b1,2'd0,3'd0,E_FB,  1'b0},
        '{1'b0,1'b0,1'b1,2'b11,2'd2,1'b1,2'd0,3'd0,E_WR,  1'b1},
        '{1'b1,1'b0,1'b0,2'b11,2'd2,1'b1,2'd0,3'd1,E_WR,  1'b1},
        '{1'b1,1'b0,1'b0,2'b10,2'd1,1'b1,2'd0,3'd0,E_WAKE,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_val = 1'b0;
    logic        prot_en = 1'b0;
    logic [31:0] stored_pwd = PWD;
    logic [3:0]  master_key = 4'd0;
    logic        blk0_lock = 1'b0;
    logic        wr_req, wr_test, wr_page, wr_lock, rst_req, wake, fallback, rd_page;
    logic [2:0]  wr_blk;
    logic [31:0] wr_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int          n_wr, n_test, n_rst, n_wake, n_fb, first_idx;
    logic [2:0]  c_blk;
    logic [31:0] c_data;
    logic        c_lock, c_page;

    always #10 clk = ~clk;

    cmd_seq_parser dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
        .bit_valid(bit_valid), .bit_val(bit_val), .prot_en(prot_en),
        .stored_pwd(stored_pwd), .master_key(master_key), .blk0_lock(blk0_lock),
        .wr_req(wr_req), .wr_test(wr_test), .wr_page(wr_page), .wr_blk(wr_blk),
        .wr_lock(wr_lock), .wr_data(wr_data), .rst_req(rst_req), .wake(wake),
        .fallback(fallback), .rd_page(rd_page)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] e);
        case (e)
            E_WR:    return "R2/R3";
            E_TEST:  return "R6";
            E_RST:   return "R5";
            E_WAKE:  return "R4";
            E_FB:    return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic send(input logic [127:0] f, input int n,
                        input bit with_start, input bit coincide);
        if (with_start) begin
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        for (int i = n - 1; i >= 0; i--) begin
            bit_valid = 1'b1;
            bit_val   = f[i];
            if (i == 0 && coincide) frame_end = 1'b1;
            @(negedge clk);
            bit_valid = 1'b0;
            frame_end = 1'b0;
            if (!(i == 0 && coincide)) @(negedge clk);
        end
        if (!coincide || n == 0) begin
            frame_end = 1'b1;
            @(negedge clk);
            frame_end = 1'b0;
        end
    endtask

    task automatic observe();
        n_wr = 0; n_test = 0; n_rst = 0; n_wake = 0; n_fb = 0; first_idx = -1;
        for (int k = 0; k < 4; k++) begin
            if (wr_req || rst_req || wake || fallback)
                if (first_idx < 0) first_idx = k;
            if (wr_req && wr_test) n_test++;
            else if (wr_req) n_wr++;
            if (wr_req) begin
                c_blk = wr_blk; c_data = wr_data; c_lock = wr_lock; c_page = wr_page;
            end
            if (rst_req)  n_rst++;
            if (wake)     n_wake++;
            if (fallback) n_fb++;
            @(negedge clk);
        end
    endtask

    function automatic logic [14:0] counts_word(input int a, input int b, input int c,
                                                input int d, input int e);
        return {3'(a), 3'(b), 3'(c), 3'(d), 3'(e)};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] f;
        int           n;
        logic [31:0]  data;
        logic         lock;
        logic [14:0]  expc;

        repeat (3) @(negedge clk);
        // R8: reset state
        chk(rd_page == 1'b0, "R8", "reset rd_page", 64'(rd_page), 64'd0);
        chk({wr_req, rst_req, wake, fallback} == 4'b0, "R8", "reset strobes",
            64'({wr_req, rst_req, wake, fallback}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit   with_pwd;
            v = TBL[i];
            prot_en    = v.prot;
            master_key = v.key6 ? 4'd6 : 4'd0;
            blk0_lock  = v.lk0;
            data = 32'h5A3C0F00 ^ (32'(i) * 32'h01011011);
            lock = i[0];
            with_pwd = (v.shape == 2'd1) || (v.prot && v.op[1] && v.shape == 2'd2);
            f = 128'(v.op);
            n = 2;
            if (with_pwd) begin
                f = (f << 32) | 128'(v.pgood ? PWD : (PWD ^ 32'h00008000));
                n += 32;
            end
            if (v.shape == 2'd2) begin
                f = (f << 36) | 128'({lock, data, v.addr});
                n += 36;
            end
            if (v.trim == 2'd1) begin
                f = f >> 1;
                n -= 1;
            end else if (v.trim == 2'd2) begin
                f = (f << 1) | 128'd1;
                n += 1;
            end
            // R9: odd rows end the frame together with the last bit
            send(f, n, 1'b1, i[0]);
            observe();
            expc = counts_word(v.exp == E_WR, v.exp == E_TEST, v.exp == E_RST,
                               v.exp == E_WAKE, v.exp == E_FB);
            chk(counts_word(n_wr, n_test, n_rst, n_wake, n_fb) == expc, req_of(v.exp),
                $sformatf("row %0d verdict counts", i),
                64'(counts_word(n_wr, n_test, n_rst, n_wake, n_fb)), 64'(expc));
            if (v.exp != E_NONE)
                chk(first_idx == 1, "R9", $sformatf("row %0d strobe timing", i),
                    64'(first_idx), 64'd1);
            if (v.exp == E_WR || v.exp == E_TEST) begin
                chk(c_data == data, "R2", $sformatf("row %0d data", i), 64'(c_data), 64'(data));
                chk(c_blk == v.addr, "R2", $sformatf("row %0d block", i), 64'(c_blk), 64'(v.addr));
                chk(c_lock == lock, "R2", $sformatf("row %0d lock", i), 64'(c_lock), 64'(lock));
                chk(c_page == ((v.exp == E_TEST) ? 1'b0 : v.op[0]), "R6",
                    $sformatf("row %0d write page", i), 64'(c_page),
                    64'((v.exp == E_TEST) ? 1'b0 : v.op[0]));
            end
            chk(rd_page == v.exp_page, "R8", $sformatf("row %0d rd_page", i),
                64'(rd_page), 64'(v.exp_page));
        end

        prot_en = 1'b0; master_key = 4'd0; blk0_lock = 1'b0;

        // R11: restart inside an open frame
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            bit_valid = 1'b1; bit_val = i[0]; @(negedge clk); bit_valid = 1'b0; @(negedge clk);
        end
        f = (128'(2'b11) << 36) | 128'({1'b0, 32'h13572468, 3'd4});
        send(f, 38, 1'b1, 1'b0);
        observe();
        chk(n_wr == 1 && n_fb == 0 && c_data == 32'h13572468, "R11", "restart write",
            64'(c_data), 64'h13572468);
        chk(rd_page == 1'b1, "R11", "restart page", 64'(rd_page), 64'd1);

        // R1: bits outside a frame are ignored
        f = (128'(2'b10) << 36) | 128'({1'b1, 32'hFFFF0000, 3'd2});
        send(f, 38, 1'b0, 1'b0);
        observe();
        chk(counts_word(n_wr, n_test, n_rst, n_wake, n_fb) == 15'd0, "R1", "loose bits",
            64'(counts_word(n_wr, n_test, n_rst, n_wake, n_fb)), 64'd0);
        chk(rd_page == 1'b1, "R1", "loose bits page", 64'(rd_page), 64'd1);

        // R7: zero-bit frame
        send(128'd0, 0, 1'b1, 1'b0);
        observe();
        chk(n_fb == 1 && n_wr == 0, "R7", "empty frame fallback", 64'(n_fb), 64'd1);
        chk(rd_page == 1'b1, "R7", "empty frame page", 64'(rd_page), 64'd1);

        // R10: page-1 block 0 write with lock set already covered; page-0 block 0 denied again
        blk0_lock = 1'b1;
        f = (128'(2'b10) << 36) | 128'({1'b0, 32'h0BADF00D, 3'd0});
        send(f, 38, 1'b1, 1'b1);
        observe();
        chk(n_fb == 1 && n_wr == 0, "R10", "locked block 0", 64'(n_wr), 64'd0);
        chk(rd_page == 1'b1, "R10", "locked block 0 page", 64'(rd_page), 64'd1);
        blk0_lock = 1'b0;

        // R8: reset in the middle of a frame returns page 0
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        for (int i = 0; i < 10; i++) begin
            bit_valid = 1'b1; bit_val = 1'b1; @(negedge clk); bit_valid = 1'b0;
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk(rd_page == 1'b0, "R8", "page after reset", 64'(rd_page), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        observe();
        chk(counts_word(n_wr, n_test, n_rst, n_wake, n_fb) == 15'd0, "R1",
            "frame end after reset", 64'(counts_word(n_wr, n_test, n_rst, n_wake, n_fb)), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule